// File: doc/BRIEF.md
# AXI Channel Trigger Matcher

This block passively observes the five channels of one AXI port: write address, read address, write data, write response and read data. On every beat that completes a VALID/READY handshake, it compares the beat's payload against programmable masked conditions. It never drives or alters the bus. Each channel owns a bank of condition and mask registers. A channel fires when all of its condition/mask pairs agree at once and the channel's enable bit is set. The per-channel fire signals are brought out directly, so a logic analyser or a debug interrupt can use them.

The fire signals also feed a match counter. A configuration register selects which channels are monitored and sets a 48-bit target. Each cycle in which at least one monitored channel fires adds one to the count. When the count reaches the target, a sticky done flag is raised and counting freezes. A read-only result register returns the count and the flag.

The controlling state machine has two states. In `ST_COUNT` the counter advances. In `ST_DONE` the count is frozen and `done` is high. There are three transitions:
- `ST_COUNT -> ST_DONE` is taken when a counted cycle brings the count to a nonzero target.
- `ST_DONE -> ST_COUNT` is taken on a configuration write.
- `ST_COUNT -> ST_COUNT` on a configuration write clears the count.

Top module: `axi_trig_match`

## Requirements
- R1: A condition/mask pair matches when `((payload ^ cond) & mask) == 0`. The payload is zero-extended to 64 bits, and its fields are packed LSB-first as follows:
  - address channels: burst[1:0], size[4:2], len[12:5], id[16:13], addr[32:17]
  - write data: last[0], strb[4:1], data[36:5]
  - write response: resp[1:0], id[5:2]
  - read data: last[0], resp[2:1], id[6:3], data[38:7]
- R2: Bit 63 of a channel's first mask register is that channel's enable and is excluded from the compare. `chan_trig[c]` is high in the same cycle exactly when channel c has VALID and READY both high, is enabled, and all of its pairs match. The bit order of `chan_trig` is 0 = AW, 1 = AR, 2 = W, 3 = B, 4 = R.
- R3: Registers are 64 bits wide and are selected by word index `reg_idx`; byte offset = 8 × index. Within a channel, each condition register is directly followed by its mask. The pairs start at these indices:
  - AW: two pairs at index 0
  - AR: two pairs at index 4
  - W: three pairs at index 8
  - B: one pair at index 14
  - R: three pairs at index 16
- R4: All 22 condition and mask registers can be written and read back in full.
- R5: The configuration register is at index 22. Bits [47:0] hold the target and bits [55:48] hold the monitor enables; bits [63:56] read as zero. Monitor bit c gates channel c of R2.
- R6: The count increases by exactly one for each cycle in which any monitored channel fires, however many channels fire in that cycle. The updated count is readable after that clock edge.
- R7: When a counted cycle makes the count equal to a nonzero target, `done` rises at that edge and the count stops changing. A target of zero never raises `done`.
- R8: Writing the configuration register clears the count and `done` at that edge. This takes priority over a match in the same cycle.
- R9: The result register is at index 23 and is read-only: bits [47:0] hold the count and bit 48 holds `done`. Writes to it are ignored, and indices 24 to 31 read as zero.
- R10: After reset all registers, the count and `done` are zero, and `chan_trig` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address VALID |
| aw_ready | input | 1 | Write address READY |
| aw_addr | input | ADDR_W | Write address |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | 8 | Write burst length |
| aw_size | input | 3 | Write beat size |
| aw_burst | input | 2 | Write burst type |
| ar_valid | input | 1 | Read address VALID |
| ar_ready | input | 1 | Read address READY |
| ar_addr | input | ADDR_W | Read address |
| ar_id | input | ID_W | Read address ID |
| ar_len | input | 8 | Read burst length |
| ar_size | input | 3 | Read beat size |
| ar_burst | input | 2 | Read burst type |
| w_valid | input | 1 | Write data VALID |
| w_ready | input | 1 | Write data READY |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write strobes |
| w_last | input | 1 | Last write beat |
| b_valid | input | 1 | Write response VALID |
| b_ready | input | 1 | Write response READY |
| b_id | input | ID_W | Write response ID |
| b_resp | input | 2 | Write response code |
| r_valid | input | 1 | Read data VALID |
| r_ready | input | 1 | Read data READY |
| r_data | input | DATA_W | Read data |
| r_id | input | ID_W | Read data ID |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Last read beat |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register word index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| chan_trig | output | 5 | Per-channel fire, same cycle as the beat |
| done | output | 1 | Sticky target-reached flag |

## Verification
There are three kinds of result, each due at a different time:
- **`chan_trig`** is combinational. It is sampled 1 ns after the payload and handshake are driven, well before the next rising edge.
- **Count and `done`** are due one rising edge after the handshaking cycle. The bench drives each beat at a falling edge and reads them back 1 ns after the following rising edge.
- **Register reads** are combinational, so each readback is taken 1 ns after the index is applied.

A configuration write and a match are placed in the same cycle to show that the clear wins at that one edge.

// File: rtl/atm_pkg.sv
`timescale 1ns/1ps
package atm_pkg;
    localparam int REG_W   = 64;
    localparam int CNT_W   = 48;
    localparam int MON_W   = 8;
    localparam int NCH     = 5;
    localparam int IDX_W   = 5;
    localparam int CM_REGS = 22;
    localparam int IDX_CFG = 22;
    localparam int IDX_RES = 23;

    typedef enum logic [2:0] {
        CH_AW = 3'd0,
        CH_AR = 3'd1,
        CH_W  = 3'd2,
        CH_B  = 3'd3,
        CH_R  = 3'd4
    } chan_e;

    localparam int NP_AW = 2;
    localparam int NP_AR = 2;
    localparam int NP_W  = 3;
    localparam int NP_B  = 1;
    localparam int NP_R  = 3;

    localparam int BASE_AW = 0;
    localparam int BASE_AR = BASE_AW + 2 * NP_AW;
    localparam int BASE_W  = BASE_AR + 2 * NP_AR;
    localparam int BASE_B  = BASE_W  + 2 * NP_W;
    localparam int BASE_R  = BASE_B  + 2 * NP_B;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_DONE  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/atm_regbank.sv
`timescale 1ns/1ps
module atm_regbank
    import atm_pkg::*;
#(
    parameter int NREG = CM_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [REG_W-1:0]       wdata,
    input  logic [CNT_W-1:0]       count,
    input  logic                   done,
    output logic [REG_W-1:0]       rdata,
    output logic [NREG*REG_W-1:0]  cm_flat,
    output logic [CNT_W-1:0]       cfg_target,
    output logic [NCH-1:0]         cfg_mon,
    output logic                   cfg_wr
);
    localparam int CFG_W = CNT_W + MON_W;

    logic [REG_W-1:0] cm_q [NREG];
    logic [CFG_W-1:0] cfg_q;

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_cm
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cm_q[gi] <= '0;
                end else if (we && (idx == IDX_W'(gi))) begin
                    cm_q[gi] <= wdata;
                end
            end
            assign cm_flat[gi*REG_W +: REG_W] = cm_q[gi];
        end
    endgenerate

    assign cfg_wr = we && (idx == IDX_W'(IDX_CFG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= wdata[CFG_W-1:0];
        end
    end

    assign cfg_target = cfg_q[CNT_W-1:0];
    assign cfg_mon    = cfg_q[CNT_W +: NCH];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i)) rdata = cm_q[i];
        end
        if (idx == IDX_W'(IDX_CFG)) rdata = REG_W'(cfg_q);
        if (idx == IDX_W'(IDX_RES)) rdata = REG_W'({done, count});
    end
endmodule

// File: rtl/atm_chan_match.sv
`timescale 1ns/1ps
module atm_chan_match
    import atm_pkg::*;
#(
    parameter int PW    = 33,
    parameter int NPAIR = 2
) (
    input  logic [PW-1:0]            payload,
    input  logic                     hs,
    input  logic [NPAIR*2*REG_W-1:0] cm,
    output logic                     trig
);
    localparam int PAD = REG_W - PW;

    logic [REG_W-1:0] pay64;
    logic [NPAIR-1:0] pair_ok;
    logic             enable;

    assign pay64  = {{PAD{1'b0}}, payload};
    assign enable = cm[REG_W + REG_W - 1];

    genvar gk;
    generate
        for (gk = 0; gk < NPAIR; gk++) begin : g_pair
            logic [REG_W-1:0] cond;
            logic [REG_W-1:0] mask_eff;
            assign cond = cm[(2*gk)*REG_W +: REG_W];
            if (gk == 0) begin : g_first
                assign mask_eff = {1'b0, cm[REG_W +: REG_W-1]};
            end else begin : g_rest
                assign mask_eff = cm[(2*gk+1)*REG_W +: REG_W];
            end
            assign pair_ok[gk] = ((pay64 ^ cond) & mask_eff) == '0;
        end
    endgenerate

    assign trig = hs && enable && (&pair_ok);
endmodule

// File: rtl/atm_count_fsm.sv
`timescale 1ns/1ps
module atm_count_fsm
    import atm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;

    assign count_inc = count_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (!cfg_wr && hit && (target != '0) && (count_inc == target))
                    state_d = ST_DONE;
            end
            ST_DONE: begin
                if (cfg_wr) state_d = ST_COUNT;
            end
            default: state_d = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cfg_wr) begin
            count_q <= '0;
        end else if ((state_q == ST_COUNT) && hit) begin
            count_q <= count_inc;
        end
    end

    always_comb begin
        done  = (state_q == ST_DONE);
        count = count_q;
    end
endmodule

// File: rtl/axi_trig_match.sv
`timescale 1ns/1ps
module axi_trig_match
    import atm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                aw_valid,
    input  logic                aw_ready,
    input  logic [ADDR_W-1:0]   aw_addr,
    input  logic [ID_W-1:0]     aw_id,
    input  logic [7:0]          aw_len,
    input  logic [2:0]          aw_size,
    input  logic [1:0]          aw_burst,
    input  logic                ar_valid,
    input  logic                ar_ready,
    input  logic [ADDR_W-1:0]   ar_addr,
    input  logic [ID_W-1:0]     ar_id,
    input  logic [7:0]          ar_len,
    input  logic [2:0]          ar_size,
    input  logic [1:0]          ar_burst,
    input  logic                w_valid,
    input  logic                w_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic                b_valid,
    input  logic                b_ready,
    input  logic [ID_W-1:0]     b_id,
    input  logic [1:0]          b_resp,
    input  logic                r_valid,
    input  logic                r_ready,
    input  logic [DATA_W-1:0]   r_data,
    input  logic [ID_W-1:0]     r_id,
    input  logic [1:0]          r_resp,
    input  logic                r_last,
    input  logic                reg_we,
    input  logic [4:0]          reg_idx,
    input  logic [63:0]         reg_wdata,
    output logic [63:0]         reg_rdata,
    output logic [4:0]          chan_trig,
    output logic                done
);
    localparam int STRB_W = DATA_W / 8;
    localparam int AX_PW  = ADDR_W + ID_W + 13;
    localparam int W_PW   = DATA_W + STRB_W + 1;
    localparam int B_PW   = ID_W + 2;
    localparam int R_PW   = DATA_W + ID_W + 3;

    logic [CM_REGS*REG_W-1:0] cm_flat;
    logic [CNT_W-1:0]         cfg_target;
    logic [NCH-1:0]           cfg_mon;
    logic                     cfg_wr;
    logic [CNT_W-1:0]         count_q;
    logic [NCH-1:0]           hs_vec;
    logic                     hit;

    logic [AX_PW-1:0] aw_pay, ar_pay;
    logic [W_PW-1:0]  w_pay;
    logic [B_PW-1:0]  b_pay;
    logic [R_PW-1:0]  r_pay;

    assign aw_pay = {aw_addr, aw_id, aw_len, aw_size, aw_burst};
    assign ar_pay = {ar_addr, ar_id, ar_len, ar_size, ar_burst};
    assign w_pay  = {w_data, w_strb, w_last};
    assign b_pay  = {b_id, b_resp};
    assign r_pay  = {r_data, r_id, r_resp, r_last};

    assign hs_vec[CH_AW] = aw_valid & aw_ready;
    assign hs_vec[CH_AR] = ar_valid & ar_ready;
    assign hs_vec[CH_W]  = w_valid  & w_ready;
    assign hs_vec[CH_B]  = b_valid  & b_ready;
    assign hs_vec[CH_R]  = r_valid  & r_ready;

    atm_regbank #(.NREG(CM_REGS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .count      (count_q),
        .done       (done),
        .rdata      (reg_rdata),
        .cm_flat    (cm_flat),
        .cfg_target (cfg_target),
        .cfg_mon    (cfg_mon),
        .cfg_wr     (cfg_wr)
    );

    atm_chan_match #(.PW(AX_PW), .NPAIR(NP_AW)) u_m_aw (
        .payload (aw_pay),
        .hs      (hs_vec[CH_AW]),
        .cm      (cm_flat[BASE_AW*REG_W +: 2*NP_AW*REG_W]),
        .trig    (chan_trig[CH_AW])
    );

    atm_chan_match #(.PW(AX_PW), .NPAIR(NP_AR)) u_m_ar (
        .payload (ar_pay),
        .hs      (hs_vec[CH_AR]),
        .cm      (cm_flat[BASE_AR*REG_W +: 2*NP_AR*REG_W]),
        .trig    (chan_trig[CH_AR])
    );

    atm_chan_match #(.PW(W_PW), .NPAIR(NP_W)) u_m_w (
        .payload (w_pay),
        .hs      (hs_vec[CH_W]),
        .cm      (cm_flat[BASE_W*REG_W +: 2*NP_W*REG_W]),
        .trig    (chan_trig[CH_W])
    );

    atm_chan_match #(.PW(B_PW), .NPAIR(NP_B)) u_m_b (
        .payload (b_pay),
        .hs      (hs_vec[CH_B]),
        .cm      (cm_flat[BASE_B*REG_W +: 2*NP_B*REG_W]),
        .trig    (chan_trig[CH_B])
    );

    atm_chan_match #(.PW(R_PW), .NPAIR(NP_R)) u_m_r (
        .payload (r_pay),
        .hs      (hs_vec[CH_R]),
        .cm      (cm_flat[BASE_R*REG_W +: 2*NP_R*REG_W]),
        .trig    (chan_trig[CH_R])
    );

    assign hit = |(chan_trig & cfg_mon);

    atm_count_fsm u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .cfg_wr (cfg_wr),
        .target (cfg_target),
        .count  (count_q),
        .done   (done)
    );
endmodule

// File: rtl/atm_checker.sv
`timescale 1ns/1ps
module atm_checker
    import atm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   hs,
    input logic [NCH-1:0]   trig,
    input logic [NCH-1:0]   mon,
    input logic             cfg_wr,
    input logic [CNT_W-1:0] target,
    input logic [CNT_W-1:0] count,
    input logic             done
);
    AST_TRIG_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig & ~hs) == '0); // R2

    AST_COUNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1))); // R6

    AST_NO_HIT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && ((trig & mon) == '0)) |=> $stable(count)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_wr) |=> (done && $stable(count))); // R7

    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == target) && (target != '0)); // R7

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (count == '0) && !done); // R8
endmodule

bind axi_trig_match atm_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs     (hs_vec),
    .trig   (chan_trig),
    .mon    (cfg_mon),
    .cfg_wr (cfg_wr),
    .target (cfg_target),
    .count  (count_q),
    .done   (done)
);

// File: tb/axi_trig_match_tb.sv
`timescale 1ns/1ps
module axi_trig_match_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 0, aw_ready = 0, ar_valid = 0, ar_ready = 0;
    logic [15:0] aw_addr = 0, ar_addr = 0;
    logic [3:0]  aw_id = 0, ar_id = 0, b_id = 0, r_id = 0;
    logic [7:0]  aw_len = 0, ar_len = 0;
    logic [2:0]  aw_size = 0, ar_size = 0;
    logic [1:0]  aw_burst = 0, ar_burst = 0, b_resp = 0, r_resp = 0;
    logic        w_valid = 0, w_ready = 0, w_last = 0;
    logic [31:0] w_data = 0, r_data = 0;
    logic [3:0]  w_strb = 0;
    logic        b_valid = 0, b_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_idx = 0;
    logic [63:0] reg_wdata = 0;
    logic [63:0] reg_rdata;
    logic [4:0]  chan_trig;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] rng = 64'h1234_5678_9abc_def1;

    always #5 clk = ~clk;

    axi_trig_match u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic next_rand(output logic [63:0] v);
        rng = rng * 64'd6364136223846793005 + 64'd1442695040888963407;
        v = rng ^ (rng >> 29);
    endtask

    task automatic wr(input int idx, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 5'(idx); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [63:0] d);
        reg_idx = 5'(idx);
        #1;
        d = reg_rdata;
    endtask

    // Drive one channel's payload from a packed vector using the R1 field order.
    task automatic drive(input int c, input logic [63:0] p, input logic v, input logic rdy);
        aw_valid = 0; aw_ready = 0; ar_valid = 0; ar_ready = 0; w_valid = 0; w_ready = 0;
        b_valid = 0; b_ready = 0; r_valid = 0; r_ready = 0;
        case (c)
            0: begin
                aw_burst = p[1:0]; aw_size = p[4:2]; aw_len = p[12:5];
                aw_id = p[16:13]; aw_addr = p[32:17]; aw_valid = v; aw_ready = rdy;
            end
            1: begin
                ar_burst = p[1:0]; ar_size = p[4:2]; ar_len = p[12:5];
                ar_id = p[16:13]; ar_addr = p[32:17]; ar_valid = v; ar_ready = rdy;
            end
            2: begin
                w_last = p[0]; w_strb = p[4:1]; w_data = p[36:5]; w_valid = v; w_ready = rdy;
            end
            3: begin
                b_resp = p[1:0]; b_id = p[5:2]; b_valid = v; b_ready = rdy;
            end
            default: begin
                r_last = p[0]; r_resp = p[2:1]; r_id = p[6:3]; r_data = p[38:7];
                r_valid = v; r_ready = rdy;
            end
        endcase
    endtask

    // One clock with the given handshakes held, sampled trigger returned.
    task automatic beat(input logic [4:0] vld, input logic [4:0] rdy, output logic [4:0] tr);
        @(negedge clk);
        aw_valid = vld[0]; ar_valid = vld[1]; w_valid = vld[2]; b_valid = vld[3]; r_valid = vld[4];
        aw_ready = rdy[0]; ar_ready = rdy[1]; w_ready = rdy[2]; b_ready = rdy[3]; r_ready = rdy[4];
        #1 tr = chan_trig;
        @(posedge clk); #1;
        drive(0, 64'd0, 1'b0, 1'b0);
    endtask

    task automatic clear_regs();
        for (int i = 0; i < 22; i++) wr(i, 64'd0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [4:0]  tr;
        int pw[5]   = '{33, 33, 37, 6, 39};
        int np[5]   = '{2, 2, 3, 1, 3};
        int base[5] = '{0, 4, 8, 14, 16};

        #23 rst_n = 1'b1;
        #1;
        // R10 reset state
        rd(23, d); chk("R10 result after reset", d, 64'd0);
        rd(22, d); chk("R10 config after reset", d, 64'd0);
        rd(5, d);  chk("R10 cond/mask after reset", d, 64'd0);
        chk("R10 trig after reset", {59'd0, chan_trig}, 64'd0);
        chk("R10 done after reset", {63'd0, done}, 64'd0);

        // R4 full readback sweep, R3 index layout
        for (int i = 0; i < 22; i++) wr(i, 64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101));
        for (int i = 0; i < 22; i++) begin
            rd(i, d);
            chk("R4 readback", d, 64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101));
        end
        clear_regs();

        // R5 config field widths
        wr(22, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(22, d); chk("R5 config upper byte reads zero", d, 64'h00FF_FFFF_FFFF_FFFF);
        wr(22, 64'd0);

        // R9 result is read-only, unmapped reads zero
        wr(23, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(23, d); chk("R9 result write ignored", d, 64'd0);
        wr(27, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(27, d); chk("R9 unmapped reads zero", d, 64'd0);
        rd(0, d);  chk("R9 unmapped write no side effect", d, 64'd0);

        // R1 R2 R3 match sweep per channel
        for (int c = 0; c < 5; c++) begin
            clear_regs();
            for (int it = 0; it < 40; it++) begin
                logic [63:0] p, r1, r2, r3, r4, r5, cd, mk, me, pmask;
                logic en, ok, v, rdy, exp_t;
                pmask = (64'd1 << pw[c]) - 64'd1;
                next_rand(r1);
                p = r1 & pmask;
                ok = 1'b1; en = 1'b0;
                for (int k = 0; k < np[c]; k++) begin
                    next_rand(r1); next_rand(r2); next_rand(r3); next_rand(r4); next_rand(r5);
                    mk = r1 & r2;
                    cd = (p & mk) | (r3 & ~mk);
                    if (r4[2:0] == 3'd0) cd = cd ^ (r5 & mk);
                    me = mk;
                    if (k == 0) begin
                        mk[63] = r4[8] | r4[9];
                        cd[63] = r4[10];
                        me = {1'b0, mk[62:0]};
                        en = mk[63];
                    end
                    if (((p ^ cd) & me) != 64'd0) ok = 1'b0;
                    wr(base[c] + 2*k, cd);
                    wr(base[c] + 2*k + 1, mk);
                end
                next_rand(r4);
                v = r4[0] | r4[1];
                rdy = r4[2] | r4[3];
                exp_t = ok & en & v & rdy;
                drive(c, p, v, rdy);
                #1;
                chk("R1 R2 R3 channel trigger", {59'd0, chan_trig},
                    exp_t ? (64'd1 << c) : 64'd0);
                drive(c, 64'd0, 1'b0, 1'b0);
            end
        end

        // R6 R7 R8 counting: AW, W, B enabled with empty compare
        clear_regs();
        wr(1, 64'h8000_0000_0000_0000);
        wr(9, 64'h8000_0000_0000_0000);
        wr(15, 64'h8000_0000_0000_0000);
        wr(22, (64'h05 << 48) | 64'd5);           // monitor AW and W, target 5
        for (int i = 0; i < 3; i++) beat(5'b00101, 5'b00101, tr);
        rd(23, d); chk("R6 two channels one cycle count once", d, 64'd3);
        beat(5'b00001, 5'b00000, tr);
        chk("R2 no trigger without READY", {59'd0, tr}, 64'd0);
        rd(23, d); chk("R6 no count without handshake", d, 64'd3);
        beat(5'b01000, 5'b01000, tr);
        chk("R5 unmonitored channel still fires", {59'd0, tr}, 64'd8);
        rd(23, d); chk("R5 unmonitored channel not counted", d, 64'd3);
        beat(5'b00001, 5'b00001, tr);
        rd(23, d); chk("R7 below target", d, 64'd4);
        chk("R7 done low below target", {63'd0, done}, 64'd0);
        beat(5'b00001, 5'b00001, tr);
        rd(23, d); chk("R7 target reached result", d, (64'd1 << 48) | 64'd5);
        chk("R7 done port at target", {63'd0, done}, 64'd1);
        beat(5'b00101, 5'b00101, tr);
        beat(5'b00001, 5'b00001, tr);
        rd(23, d); chk("R7 count frozen after done", d, (64'd1 << 48) | 64'd5);

        wr(22, (64'h01 << 48));                   // target 0, monitor AW
        rd(23, d); chk("R8 config write clears", d, 64'd0);
        chk("R8 done cleared", {63'd0, done}, 64'd0);
        for (int i = 0; i < 4; i++) beat(5'b00001, 5'b00001, tr);
        rd(23, d); chk("R7 zero target never done", d, 64'd4);

        // R8 clear wins over a same-cycle match
        @(negedge clk);
        aw_valid = 1; aw_ready = 1;
        reg_we = 1; reg_idx = 5'd22; reg_wdata = (64'h01 << 48) | 64'd2;
        @(posedge clk); #1;
        reg_we = 0; drive(0, 64'd0, 1'b0, 1'b0);
        rd(23, d); chk("R8 clear beats same-cycle hit", d, 64'd0);
        beat(5'b00001, 5'b00001, tr);
        beat(5'b00001, 5'b00001, tr);
        rd(23, d); chk("R7 new target reached", d, (64'd1 << 48) | 64'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule